// File: doc/BRIEF.md
# Dual-Modulus PLL Feedback Divider

This block divides the oscillator clock of a phase-locked loop down to the rate of the phase detector. It produces a one-cycle pulse once every N cycles of the oscillator clock. A prescaler, a swallow counter and a main counter are chained to set N. The prescaler has two modes. In fixed mode it divides by a constant ratio of 1, 2 or 3. In dual-modulus mode it divides by either P or P+1, with P one of 2, 4, 8, 16 or 32.

In dual-modulus mode the main counter counts B prescaler periods to make one output period. The swallow counter makes the first A of those periods use the modulus P+1, so N = P·B + A. In fixed mode N = P·B. If the main counter is bypassed, B counts as 1 and N = P, which reaches the smallest divide values. A synchronous counter-reset input holds all counters at their start point. A configuration check flags settings that cannot be honoured and keeps the counters idle while they stand. The settings may only change while the counter reset is held. The first pulse comes exactly N cycles after the reset is released.

Top module: `dm_fb_divider`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` is low. It goes low at once when `rst_n` falls, with no clock edge needed.
- R2: Fixed mode (`cfg_mode`=0) uses `cfg_psel` 0, 1 and 2 for divide ratios 1, 2 and 3. Without bypass, `fb_pulse` repeats every P·B cycles, where B = `cfg_b`.
- R3: Dual-modulus mode (`cfg_mode`=1) uses `cfg_psel` values 0 to 4 for P = 2, 4, 8, 16 and 32. `fb_pulse` repeats every P·B + A cycles, with A = `cfg_a`, and this includes the boundary case A = B.
- R4: With `cfg_bbyp`=1 in fixed mode, the value of `cfg_b` is ignored (0 is accepted) and `fb_pulse` repeats every P cycles. With P = 1, `fb_pulse` is high on every cycle.
- R5: In fixed mode `cfg_a` has no effect on the period, even when it exceeds `cfg_b`.
- R6: `cfg_err` is high for any of these settings: dual mode with A > B; bypass in dual mode; B = 0 without bypass; `cfg_psel` above 4 in dual mode or above 2 in fixed mode. While `cfg_err` is high, `fb_pulse` stays low.
- R7: While `cnt_rst` is high, `fb_pulse` is low one cycle later. After `cnt_rst` is sampled low, the first pulse appears N rising edges later, and pulses then follow every N cycles.
- R8: Each pulse is one clock cycle wide whenever N > 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_rst | input | 1 | Synchronous hold of all counters at their start point |
| cfg_mode | input | 1 | 0 = fixed divide, 1 = dual modulus |
| cfg_psel | input | 3 | Prescaler ratio select (encoding per mode) |
| cfg_a | input | A_W (6) | Swallow count A |
| cfg_b | input | B_W (13) | Main count B |
| cfg_bbyp | input | 1 | Bypass the main counter (B taken as 1) |
| fb_pulse | output | 1 | Divided feedback pulse, one cycle wide |
| cfg_err | output | 1 | Current settings are illegal; counters idle |

## Verification
The hardest case to reach is the last period before a wrap when A equals B. There the swallow counter empties on the same prescaler tick that wraps the main counter, and the reload has to take priority. Directed settings with A = B and with P = 32 put the bench on that tick. Constrained random settings then place A anywhere from 0 to B, and sometimes one count beyond B to trigger the error check. A second hard case is a counter reset arriving mid-period. The bench asserts it partway through a period and then checks that the next pulse comes exactly N edges after release.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Prescaler counter width: the largest modulus is 32+1 = 33.
  localparam int unsigned PRE_W  = 6;
  localparam int unsigned PSEL_W = 3;

  typedef enum logic {
    PS_FIXED = 1'b0,
    PS_DUAL  = 1'b1
  } ps_mode_e;

  // Base modulus P for a given mode and select.
  function automatic logic [PRE_W-1:0] base_modulus(input ps_mode_e mode,
                                                    input logic [PSEL_W-1:0] sel);
    logic [PRE_W-1:0] p;
    if (mode == PS_DUAL) p = PRE_W'(2) << sel;
    else                 p = PRE_W'(sel) + PRE_W'(1);
    return p;
  endfunction

endpackage

// File: rtl/fbdiv_cfgchk.sv
module fbdiv_cfgchk
  import fbdiv_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 13
) (
  input  ps_mode_e          mode,
  input  logic [PSEL_W-1:0] psel,
  input  logic [A_W-1:0]    a_val,
  input  logic [B_W-1:0]    b_val,
  input  logic              b_bypass,
  output logic              bad,
  output logic [PRE_W-1:0]  p_base,
  output logic [A_W-1:0]    a_load,
  output logic [B_W-1:0]    b_term
);

  localparam logic [PSEL_W-1:0] DUAL_SEL_MAX  = PSEL_W'(4);
  localparam logic [PSEL_W-1:0] FIXED_SEL_MAX = PSEL_W'(2);

  logic            sel_bad;
  logic            a_over_b;
  logic            b_zero;
  logic [B_W-1:0]  b_eff;

  always_comb begin
    sel_bad  = (mode == PS_DUAL) ? (psel > DUAL_SEL_MAX) : (psel > FIXED_SEL_MAX);
    a_over_b = (mode == PS_DUAL) && (B_W'(a_val) > b_val);
    b_zero   = !b_bypass && (b_val == '0);
    bad      = sel_bad || a_over_b || b_zero || (b_bypass && (mode == PS_DUAL));
    p_base   = base_modulus(mode, psel);
    // The swallow count only exists in dual-modulus mode.
    a_load   = (mode == PS_DUAL) ? a_val : '0;
    b_eff    = b_bypass ? B_W'(1) : b_val;
    b_term   = b_eff - B_W'(1);
  end

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] modulus,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  assign tick = en && (cnt_q == (modulus - PRE_W'(1)));

  always_comb begin
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int unsigned A_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic           wrap,
  input  logic [A_W-1:0] load_val,
  output logic           active
);

  logic [A_W-1:0] rem_q;
  logic [A_W-1:0] rem_d;
  logic           rem_ce;

  assign active = (rem_q != '0);
  // The register updates while idle (reload) or on a prescaler tick.
  assign rem_ce = !en || tick;

  always_comb begin
    rem_d = rem_q;
    if (!en || wrap) rem_d = load_val;
    else if (active) rem_d = rem_q - A_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_ce) rem_q <= rem_d;
  end

endmodule

// File: rtl/fbdiv_bcount.sv
module fbdiv_bcount #(
  parameter int unsigned B_W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic [B_W-1:0] term,
  output logic           wrap,
  output logic           pulse
);

  logic [B_W-1:0] cnt_q;
  logic [B_W-1:0] cnt_d;
  logic           cnt_ce;
  logic           pulse_d;

  assign wrap   = tick && (cnt_q == term);
  assign cnt_ce = !en || tick;

  always_comb begin
    if (!en || wrap) cnt_d = '0;
    else             cnt_d = cnt_q + B_W'(1);
    pulse_d = en && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= pulse_d;
  end

endmodule

// File: rtl/dm_fb_divider.sv
module dm_fb_divider
  import fbdiv_pkg::*;
#(
  parameter int unsigned A_W         = 6,
  parameter int unsigned B_W         = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_vco,
  input  logic              rst_n,
  input  logic              cnt_rst,
  input  logic              cfg_mode,
  input  logic [PSEL_W-1:0] cfg_psel,
  input  logic [A_W-1:0]    cfg_a,
  input  logic [B_W-1:0]    cfg_b,
  input  logic              cfg_bbyp,
  output logic              fb_pulse,
  output logic              cfg_err
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   run;
  ps_mode_e               mode;
  logic [PRE_W-1:0]       p_base;
  logic [PRE_W-1:0]       modulus;
  logic [A_W-1:0]         a_load;
  logic [B_W-1:0]         b_term;
  logic                   pre_tick;
  logic                   b_wrap;
  logic                   swallow_on;

  // Reset asserts at once and releases after SYNC_STAGES clock edges.
  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign mode = ps_mode_e'(cfg_mode);
  assign run  = !cnt_rst && !cfg_err;

  fbdiv_cfgchk #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .mode     (mode),
    .psel     (cfg_psel),
    .a_val    (cfg_a),
    .b_val    (cfg_b),
    .b_bypass (cfg_bbyp),
    .bad      (cfg_err),
    .p_base   (p_base),
    .a_load   (a_load),
    .b_term   (b_term)
  );

  // While swallow periods remain, the prescaler divides by P+1.
  assign modulus = p_base + PRE_W'(swallow_on);

  fbdiv_prescaler u_pre (
    .clk     (clk_vco),
    .rst_n   (rst_int_n),
    .en      (run),
    .modulus (modulus),
    .tick    (pre_tick)
  );

  fbdiv_swallow #(.A_W(A_W)) u_swl (
    .clk      (clk_vco),
    .rst_n    (rst_int_n),
    .en       (run),
    .tick     (pre_tick),
    .wrap     (b_wrap),
    .load_val (a_load),
    .active   (swallow_on)
  );

  fbdiv_bcount #(.B_W(B_W)) u_bcnt (
    .clk   (clk_vco),
    .rst_n (rst_int_n),
    .en    (run),
    .tick  (pre_tick),
    .term  (b_term),
    .wrap  (b_wrap),
    .pulse (fb_pulse)
  );

endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk #(
  parameter int unsigned B_W = 13
) (
  input logic           clk_vco,
  input logic           rst_n,
  input logic           cnt_rst,
  input logic           cfg_err,
  input logic           fb_pulse,
  input logic           cfg_mode,
  input logic [2:0]     cfg_psel,
  input logic [B_W-1:0] cfg_b,
  input logic           cfg_bbyp
);

  logic n_is_one;
  assign n_is_one = !cfg_mode && (cfg_psel == 3'd0) && (cfg_bbyp || (cfg_b == B_W'(1)));

  // R1
  pulse_in_reset_chk: assert property (@(posedge clk_vco) !rst_n |-> !fb_pulse);

  // R6
  err_silences_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    cfg_err |=> !fb_pulse);

  // R7
  cnt_hold_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    cnt_rst |=> !fb_pulse);

  // R8
  single_width_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (fb_pulse && !n_is_one && !cnt_rst) |=> !fb_pulse);

endmodule

bind dm_fb_divider fbdiv_chk #(.B_W(B_W)) u_chk (
  .clk_vco  (clk_vco),
  .rst_n    (rst_n),
  .cnt_rst  (cnt_rst),
  .cfg_err  (cfg_err),
  .fb_pulse (fb_pulse),
  .cfg_mode (cfg_mode),
  .cfg_psel (cfg_psel),
  .cfg_b    (cfg_b),
  .cfg_bbyp (cfg_bbyp)
);

// File: tb/dm_fb_divider_tb.sv
module dm_fb_divider_tb;

  localparam int A_W = 6;
  localparam int B_W = 13;

  logic           clk_vco = 1'b0;
  logic           rst_n;
  logic           cnt_rst;
  logic           cfg_mode;
  logic [2:0]     cfg_psel;
  logic [A_W-1:0] cfg_a;
  logic [B_W-1:0] cfg_b;
  logic           cfg_bbyp;
  logic           fb_pulse;
  logic           cfg_err;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk_vco = ~clk_vco;

  dm_fb_divider #(.A_W(A_W), .B_W(B_W)) u_dut (
    .clk_vco (clk_vco), .rst_n (rst_n), .cnt_rst (cnt_rst),
    .cfg_mode (cfg_mode), .cfg_psel (cfg_psel), .cfg_a (cfg_a),
    .cfg_b (cfg_b), .cfg_bbyp (cfg_bbyp),
    .fb_pulse (fb_pulse), .cfg_err (cfg_err)
  );

  function automatic bit exp_bad(bit m, int sel, int a, int b, bit byp);
    if (m && sel > 4) return 1;
    if (!m && sel > 2) return 1;
    if (m && byp) return 1;
    if (!byp && b == 0) return 1;
    if (m && a > b) return 1;
    return 0;
  endfunction

  function automatic int exp_n(bit m, int sel, int a, int b, bit byp);
    int p;
    p = m ? (2 << sel) : (sel + 1);
    if (m) return p * b + a;
    return p * (byp ? 1 : b);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Load a setting under counter reset, release it, then follow the pulses.
  task automatic run_cfg(string req, bit m, int sel, int a, int b, bit byp, int periods);
    bit bad;
    int n;
    int cyc;
    bad = exp_bad(m, sel, a, b, byp);
    n   = exp_n(m, sel, a, b, byp);
    @(negedge clk_vco);
    cnt_rst  = 1'b1;
    cfg_mode = m; cfg_psel = 3'(sel); cfg_a = A_W'(a); cfg_b = B_W'(b); cfg_bbyp = byp;
    @(negedge clk_vco);
    check(cfg_err == bad, req, cfg_err, bad);
    check(fb_pulse == 1'b0, "R7", fb_pulse, 0);
    @(negedge clk_vco);
    cnt_rst = 1'b0;
    cyc = bad ? 30 : n * periods + 1;
    for (int c = 1; c <= cyc; c++) begin
      bit e;
      @(negedge clk_vco);
      e = bad ? 1'b0 : ((c % n) == 0);
      check(fb_pulse == e, bad ? "R6" : req, fb_pulse, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_vco);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20417);
    rst_n = 1'b1; cnt_rst = 1'b1;
    cfg_mode = 1'b0; cfg_psel = 3'd1; cfg_a = '0; cfg_b = 13'd3; cfg_bbyp = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk_vco);
    check(fb_pulse == 1'b0, "R1", fb_pulse, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_vco);

    run_cfg("R2", 0, 2, 0, 5, 0, 3);       // divide 3, B=5 -> 15
    run_cfg("R2", 0, 1, 0, 7, 0, 2);       // divide 2, B=7 -> 14
    run_cfg("R4", 0, 0, 0, 0, 1, 4);       // N=1, B=0 ignored under bypass
    run_cfg("R4", 0, 2, 0, 0, 1, 4);       // N=3
    run_cfg("R5", 0, 1, 7, 3, 0, 3);       // A ignored in fixed mode -> 6
    run_cfg("R3", 1, 0, 0, 1, 0, 3);       // 2*1+0
    run_cfg("R3", 1, 3, 8, 8, 0, 2);       // A=B -> 136
    run_cfg("R3", 1, 4, 3, 3, 0, 2);       // 32*3+3
    run_cfg("R3", 1, 2, 1, 4, 0, 2);       // 8*4+1
    run_cfg("R6", 1, 1, 5, 4, 0, 1);       // A > B
    run_cfg("R6", 1, 1, 0, 4, 1, 1);       // bypass in dual mode
    run_cfg("R6", 0, 1, 0, 0, 0, 1);       // B = 0 without bypass
    run_cfg("R6", 1, 5, 0, 4, 0, 1);       // select out of range
    run_cfg("R6", 0, 3, 0, 4, 0, 1);       // select out of range

    // R7: counter reset mid-period, then first pulse N edges after release.
    run_cfg("R7", 1, 1, 2, 5, 0, 1);       // N=22
    repeat (9) @(negedge clk_vco);
    cnt_rst = 1'b1;
    repeat (3) begin
      @(negedge clk_vco);
      check(fb_pulse == 1'b0, "R7", fb_pulse, 0);
    end
    cnt_rst = 1'b0;
    for (int c = 1; c <= 45; c++) begin
      @(negedge clk_vco);
      check(fb_pulse == ((c % 22) == 0), "R7", fb_pulse, (c % 22) == 0);
    end

    // Constrained random settings.
    for (int k = 0; k < 24; k++) begin
      bit m, byp;
      int sel, a, b;
      m = $urandom_range(1, 0);
      b = $urandom_range(30, 1);
      if (m) begin
        sel = $urandom_range(4, 0);
        a   = $urandom_range(b, 0);
        if ($urandom_range(7, 0) == 0) a = b + 1;
        byp = 1'b0;
        run_cfg("R3", m, sel, a, b, byp, 2);
      end else begin
        sel = $urandom_range(2, 0);
        a   = $urandom_range(63, 0);
        byp = ($urandom_range(3, 0) == 0);
        run_cfg(byp ? "R4" : "R2", m, sel, a, b, byp, 3);
      end
    end

    // R1: asynchronous reset while the pulse is high (N=1).
    run_cfg("R8", 0, 0, 0, 1, 0, 3);
    @(negedge clk_vco);
    check(fb_pulse == 1'b1, "R4", fb_pulse, 1);
    rst_n = 1'b0;
    #1;
    check(fb_pulse == 1'b0, "R1", fb_pulse, 0);
    @(negedge clk_vco);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule